// File: doc/BRIEF.md
# Indexed Configuration Port with Key Unlock

This block gives a host on a simple 8-bit bus access to a configuration register space. It uses two addresses: an index port and a data port. After reset the space is locked. The host opens it by writing a two-byte key to the index port. Once the space is open, the host writes a register number to the index port and then reads or writes that register through the data port. A dedicated exit byte written to the index port locks the space again.

The register space has two parts. A small global area holds:

- the logical-device selector,
- a read-only identity byte and revision byte,
- a strap byte that reports which of the two base addresses the part was strapped to.

From index 0x30 upward, accesses go to the bank of the currently selected logical device. Each bank keeps its own activation bit at index 0x30. Higher indices are passed to external function blocks. The block gives those blocks the selected bank number, the index, the write data and one-cycle write and read strobes. It then muxes the read data of the selected device back onto the data port.

Top module: `cfg_port`

## Requirements
- R1: After synchronous reset the space is locked, the index register holds 0x00, the device selector holds 0x00 and every activation bit is 0.
- R2: Two consecutive index-port writes of 0x87 open the space. Any other index-port byte written while locked restarts the key, so 0x87, other, 0x87 leaves the space locked.
- R3: While locked, both ports read 0xFF. Data-port writes change no register and raise no function strobe.
- R4: While open, an index-port write of 0xAA locks the space and does not change the index register. After the next unlock, the index port reads back the index held before the lock.
- R5: While open, index 0x20 reads the identity parameter (default 0x52) and index 0x21 reads the revision parameter (default 0x17). Writes to either have no effect.
- R6: Index 0x26 reads the base strap input in bit 6 (0 for base 0x2E, 1 for base 0x4E). All its other bits read 0, and writes have no effect.
- R7: Index 0x07 is a read/write device selector. Its low bits drive the exported bank number.
- R8: Index 0x30 holds an activation bit in bit 0, one per logical device. A write sets or clears only the selected device's bit, and the register reads back with bits 7..1 at 0. The bits are exported as a vector.
- R9: A data-port access while open, with index above 0x30 and a selector inside the device count, raises the write or read strobe in the same cycle. It exports the index and the write data, and returns the selected device's read data on the data port.
- R10: When the selector is at or above the device count, bank indices read 0xFF. No strobe is raised and no activation bit changes.
- R11: Global indices below 0x30 other than 0x07, 0x20, 0x21 and 0x26 read 0x00, and writes to them have no effect.
- R12: While open, the index port reads back the current index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Port select: 0 index port, 1 data port |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| strap_base_hi | input | 1 | Base strap: 0 for 0x2E, 1 for 0x4E |
| fn_bank | output | DEV_W | Selected logical device number |
| fn_index | output | 8 | Current register index |
| fn_wr | output | 1 | Bank write strobe to function blocks |
| fn_rd | output | 1 | Bank read strobe to function blocks |
| fn_wdata | output | 8 | Write data to function blocks |
| fn_rdata | input | 8*NUM_DEV | Read data from each device's function block |
| fn_active | output | NUM_DEV | Activation bit of each logical device |

## Verification
The assertions check the following on every cycle:

- Nothing leaks out while locked: the ports read 0xFF and no strobe is raised.
- The second key byte opens the space and the exit byte closes it.
- The identity read matches its parameter.
- The activation vector and the bank number hold still when no write occurs.

Several behaviours are shown only by the bench's scenarios:

- the key restarting after an interrupting byte,
- the index being kept across a lock,
- per-device activation and bank read data,
- suppression with an out-of-range selector,
- the strap reflection.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam logic [7:0] KEY_ENTER   = 8'h87;
    localparam logic [7:0] KEY_EXIT    = 8'hAA;
    localparam logic [7:0] REG_DEVSEL  = 8'h07;
    localparam logic [7:0] REG_ID      = 8'h20;
    localparam logic [7:0] REG_REV     = 8'h21;
    localparam logic [7:0] REG_STRAP   = 8'h26;
    localparam logic [7:0] REG_ACT     = 8'h30;
    localparam int         STRAP_BIT   = 6;
    localparam logic       PORT_INDEX  = 1'b0;
    localparam logic       PORT_DATA   = 1'b1;
    localparam logic [7:0] IDLE_RDATA  = 8'hFF;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] idx;
        logic [7:0] wdata;
    } cfg_acc_t;

    function automatic logic is_bank_reg(input logic [7:0] idx);
        return idx >= REG_ACT;
    endfunction

    function automatic logic is_fn_reg(input logic [7:0] idx);
        return idx > REG_ACT;
    endfunction
endpackage

// File: rtl/cfg_key_lock.sv
module cfg_key_lock
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic       key_half
);
    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                LK_LOCKED: state_d = (wdata == KEY_ENTER) ? LK_HALF : LK_LOCKED;
                LK_HALF:   state_d = (wdata == KEY_ENTER) ? LK_OPEN : LK_LOCKED;
                LK_OPEN:   state_d = (wdata == KEY_EXIT)  ? LK_LOCKED : LK_OPEN;
                default:   state_d = LK_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LK_LOCKED;
        else     state_q <= state_d;
    end

    assign unlocked = (state_q == LK_OPEN);
    assign key_half = (state_q == LK_HALF);
endmodule

// File: rtl/cfg_global_file.sv
module cfg_global_file
    import cfgp_pkg::*;
#(
    parameter logic [7:0] DEV_ID  = 8'h52,
    parameter logic [7:0] DEV_REV = 8'h17
) (
    input  logic       clk,
    input  logic       rst,
    input  cfg_acc_t   acc,
    input  logic       strap_base_hi,
    output logic [7:0] devsel,
    output logic [7:0] g_rdata
);
    logic [7:0] devsel_q;

    always_ff @(posedge clk) begin
        if (rst)                                 devsel_q <= 8'h00;
        else if (acc.wr && acc.idx == REG_DEVSEL) devsel_q <= acc.wdata;
    end

    always_comb begin
        g_rdata = 8'h00;
        unique case (acc.idx)
            REG_DEVSEL: g_rdata = devsel_q;
            REG_ID:     g_rdata = DEV_ID;
            REG_REV:    g_rdata = DEV_REV;
            REG_STRAP:  g_rdata[STRAP_BIT] = strap_base_hi;
            default:    g_rdata = 8'h00;
        endcase
    end

    assign devsel = devsel_q;
endmodule

// File: rtl/cfg_bank_file.sv
module cfg_bank_file
    import cfgp_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cfg_acc_t             acc,
    input  logic [7:0]           devsel,
    input  logic [8*NUM_DEV-1:0] fn_rdata,
    output logic [NUM_DEV-1:0]   active,
    output logic                 fn_wr,
    output logic                 fn_rd,
    output logic [7:0]           bank_rdata
);
    localparam logic [8:0] DEV_LIMIT = 9'(NUM_DEV);

    logic in_range;
    logic act_wr;
    logic [NUM_DEV-1:0] act_q;

    assign in_range = {1'b0, devsel} < DEV_LIMIT;
    assign act_wr   = acc.wr && acc.idx == REG_ACT && in_range;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        always_ff @(posedge clk) begin
            if (rst)                                act_q[d] <= 1'b0;
            else if (act_wr && devsel == 8'(d))     act_q[d] <= acc.wdata[0];
        end
    end

    assign fn_wr  = acc.wr && is_fn_reg(acc.idx) && in_range;
    assign fn_rd  = acc.rd && is_fn_reg(acc.idx) && in_range;
    assign active = act_q;

    always_comb begin
        bank_rdata = IDLE_RDATA;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (devsel == 8'(d)) begin
                if (acc.idx == REG_ACT) bank_rdata = {7'b0, act_q[d]};
                else                    bank_rdata = fn_rdata[d*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/cfg_port.sv
module cfg_port
    import cfgp_pkg::*;
#(
    parameter int         NUM_DEV = 4,
    parameter logic [7:0] DEV_ID  = 8'h52,
    parameter logic [7:0] DEV_REV = 8'h17,
    localparam int        DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic                 strap_base_hi,
    output logic [DEV_W-1:0]     fn_bank,
    output logic [7:0]           fn_index,
    output logic                 fn_wr,
    output logic                 fn_rd,
    output logic [7:0]           fn_wdata,
    input  logic [8*NUM_DEV-1:0] fn_rdata,
    output logic [NUM_DEV-1:0]   fn_active
);
    logic       idx_wr;
    logic       unlocked;
    logic       key_half;
    logic [7:0] index_q;
    logic [7:0] devsel;
    logic [7:0] g_rdata;
    logic [7:0] bank_rdata;
    cfg_acc_t   acc;

    assign idx_wr = bus_wr && bus_addr == PORT_INDEX;

    cfg_key_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .unlocked (unlocked),
        .key_half (key_half)
    );

    always_ff @(posedge clk) begin
        if (rst)
            index_q <= 8'h00;
        else if (unlocked && idx_wr && bus_wdata != KEY_EXIT)
            index_q <= bus_wdata;
    end

    always_comb begin
        acc.wr    = unlocked && bus_wr && bus_addr == PORT_DATA;
        acc.rd    = unlocked && bus_rd && bus_addr == PORT_DATA;
        acc.idx   = index_q;
        acc.wdata = bus_wdata;
    end

    cfg_global_file #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_glob (
        .clk           (clk),
        .rst           (rst),
        .acc           (acc),
        .strap_base_hi (strap_base_hi),
        .devsel        (devsel),
        .g_rdata       (g_rdata)
    );

    cfg_bank_file #(.NUM_DEV(NUM_DEV)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .devsel     (devsel),
        .fn_rdata   (fn_rdata),
        .active     (fn_active),
        .fn_wr      (fn_wr),
        .fn_rd      (fn_rd),
        .bank_rdata (bank_rdata)
    );

    always_comb begin
        if (!unlocked)                  bus_rdata = IDLE_RDATA;
        else if (bus_addr == PORT_INDEX) bus_rdata = index_q;
        else if (is_bank_reg(index_q))  bus_rdata = bank_rdata;
        else                            bus_rdata = g_rdata;
    end

    assign fn_bank  = devsel[DEV_W-1:0];
    assign fn_index = index_q;
    assign fn_wdata = bus_wdata;
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
    parameter int         NUM_DEV = 4,
    parameter int         DEV_W   = 2,
    parameter logic [7:0] DEV_ID  = 8'h52
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_addr,
    input logic               bus_wr,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic               fn_wr,
    input logic               fn_rd,
    input logic [NUM_DEV-1:0] fn_active,
    input logic [DEV_W-1:0]   fn_bank,
    input logic               unlocked,
    input logic               key_half,
    input logic [7:0]         index_q
);
    AST_LOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> (!fn_wr && !fn_rd));                                   // R3
    AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> bus_rdata == 8'hFF);                                   // R3
    AST_SECOND_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (key_half && bus_wr && !bus_addr && bus_wdata == 8'h87) |=> unlocked); // R2
    AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (unlocked && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !unlocked); // R4
    AST_ID_VALUE: assert property (@(posedge clk) disable iff (rst)
        (unlocked && bus_addr && index_q == 8'h20) |-> bus_rdata == DEV_ID);  // R5
    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(fn_active));                                     // R8
    AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(fn_bank));                                       // R7
endmodule

bind cfg_port cfg_port_chk #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .DEV_ID(DEV_ID)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .fn_wr     (fn_wr),
    .fn_rd     (fn_rd),
    .fn_active (fn_active),
    .fn_bank   (fn_bank),
    .unlocked  (unlocked),
    .key_half  (key_half),
    .index_q   (index_q)
);

// File: tb/cfg_port_tb.sv
module cfg_port_tb;
    localparam int NUM_DEV = 4;
    localparam int DEV_W   = 2;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic strap_base_hi = 1'b0;
    logic [DEV_W-1:0] fn_bank;
    logic [7:0] fn_index, fn_wdata;
    logic fn_wr, fn_rd;
    logic [8*NUM_DEV-1:0] fn_rdata;
    logic [NUM_DEV-1:0] fn_active;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];

    logic s_wr, s_rd;
    logic [7:0] s_idx, s_wdata;
    logic [DEV_W-1:0] s_bank;

    always #2 clk = ~clk;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_fn
        assign fn_rdata[d*8 +: 8] = 8'(d << 5) ^ fn_index;
    end

    cfg_port u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_base_hi(strap_base_hi),
        .fn_bank(fn_bank), .fn_index(fn_index), .fn_wr(fn_wr), .fn_rd(fn_rd),
        .fn_wdata(fn_wdata), .fn_rdata(fn_rdata), .fn_active(fn_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data and compares in the read cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            if (sb.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
            else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, {24'd0, bus_rdata}, {24'd0, e.val});
            end
        end
    end

    task automatic access(input logic a, input logic w, input logic r, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        @(negedge clk);
        s_wr = fn_wr; s_rd = fn_rd; s_idx = fn_index; s_wdata = fn_wdata; s_bank = fn_bank;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr_idx(input logic [7:0] d); access(1'b0, 1'b1, 1'b0, d); endtask
    task automatic wr_dat(input logic [7:0] d); access(1'b1, 1'b1, 1'b0, d); endtask
    task automatic rd_port(input logic a, input logic [7:0] exp, input string tag);
        exp_t e;
        e.val = exp; e.tag = tag;
        sb.push_back(e);
        access(a, 1'b0, 1'b1, 8'h00);
    endtask
    task automatic rd_dat(input logic [7:0] exp, input string tag); rd_port(1'b1, exp, tag); endtask
    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d); wr_idx(i); wr_dat(d); endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 active after reset", {28'd0, fn_active}, 32'd0);
        chk("R1 bank after reset", {30'd0, fn_bank}, 32'd0);
        rd_dat(8'hFF, "R1 data read locked after reset");
        rd_port(1'b0, 8'hFF, "R3 index read locked");

        // locked writes ignored
        wr_dat(8'h55);
        chk("R3 no strobe while locked", {31'd0, s_wr}, 32'd0);

        // interrupted key
        wr_idx(8'h87); wr_idx(8'h12); wr_idx(8'h87);
        rd_dat(8'hFF, "R2 interrupted key stays locked");

        // proper key: previous single 0x87 + another 0x87 opens
        wr_idx(8'h87);
        rd_port(1'b0, 8'h00, "R12 index reads 0 after unlock");
        wr_idx(8'h07);
        rd_port(1'b0, 8'h07, "R12 index reads back");
        rd_dat(8'h00, "R1 selector zero and locked write ignored R3");

        // ID / revision
        wr_idx(8'h20); rd_dat(8'h52, "R5 identity");
        wr_dat(8'h00); rd_dat(8'h52, "R5 identity write ignored");
        wr_idx(8'h21); rd_dat(8'h17, "R5 revision");

        // strap
        wr_idx(8'h26); rd_dat(8'h00, "R6 strap low");
        strap_base_hi = 1'b1;
        rd_dat(8'h40, "R6 strap high");
        wr_dat(8'hFF); rd_dat(8'h40, "R6 strap write ignored");

        // unimplemented global
        wr_idx(8'h2A); rd_dat(8'h00, "R11 unimplemented reads 0");
        wr_dat(8'h33); rd_dat(8'h00, "R11 unimplemented write ignored");

        // selector
        reg_wr(8'h07, 8'h02);
        rd_dat(8'h02, "R7 selector readback");
        @(negedge clk);
        chk("R7 bank output", {30'd0, fn_bank}, 32'd2);

        // activation
        reg_wr(8'h30, 8'hFF);
        rd_dat(8'h01, "R8 activation readback bit0 only");
        @(negedge clk);
        chk("R8 active vector dev2", {28'd0, fn_active}, 32'h4);
        reg_wr(8'h07, 8'h01);
        reg_wr(8'h30, 8'h00);
        rd_dat(8'h00, "R8 dev1 inactive");
        @(negedge clk);
        chk("R8 other bank unchanged", {28'd0, fn_active}, 32'h4);

        // function access
        wr_idx(8'h45);
        wr_dat(8'h9C);
        chk("R9 write strobe", {31'd0, s_wr}, 32'd1);
        chk("R9 export index", {24'd0, s_idx}, 32'h45);
        chk("R9 export wdata", {24'd0, s_wdata}, 32'h9C);
        chk("R9 export bank", {30'd0, s_bank}, 32'd1);
        rd_dat(8'h65, "R9 function read data dev1");
        chk("R9 read strobe", {31'd0, s_rd}, 32'd1);
        wr_idx(8'h30);
        wr_dat(8'h00);
        chk("R9 no strobe at 0x30", {31'd0, s_wr}, 32'd0);

        // out-of-range selector
        reg_wr(8'h07, 8'h06);
        wr_idx(8'h45);
        rd_dat(8'hFF, "R10 out of range reads FF");
        chk("R10 no read strobe", {31'd0, s_rd}, 32'd0);
        wr_dat(8'h11);
        chk("R10 no write strobe", {31'd0, s_wr}, 32'd0);
        reg_wr(8'h30, 8'h01);
        @(negedge clk);
        chk("R10 activation unchanged", {28'd0, fn_active}, 32'h4);

        // exit and relock
        wr_idx(8'hAA);
        rd_dat(8'hFF, "R4 data locked after exit");
        rd_port(1'b0, 8'hFF, "R4 index locked after exit");
        wr_dat(8'h00);
        wr_idx(8'h87); wr_idx(8'h87);
        rd_port(1'b0, 8'h30, "R4 index kept across lock");
        wr_idx(8'h07);
        rd_dat(8'h06, "R4 selector kept, locked write ignored R3");

        repeat (2) @(posedge clk);
        chk("scoreboard drained", sb.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule